// File: doc/BRIEF.md
# Synchronous SRAM Access Pipeline

This block models a clocked single-port memory behind a bidirectional data bus. Commands are captured on the rising clock edge. A command carries an address, an active-low write enable, one active-low strobe for each byte lane, and three chip enables. The device counts as selected only when all three chip enables are in their active state. An active-low clock enable qualifies every edge. While it is high, the edge is ignored and the current cycle is stretched.

A read sends out the addressed word during the cycle after the edge that captured the address. A write takes its data from the bus one accepted edge after the command, and the array is updated at that same edge. The block owns the tri-state control of the bus. An asynchronous active-low output enable gates the drive. The drive is also suppressed during write data phases and whenever the previous accepted edge did not select the device. The address is used exactly as presented, and no burst sequencing is done.

Top module: `sram_pipe`

## Requirements
- R1: The device is selected at an accepted edge only when ce1_ni=0, ce2_i=1 and ce3_ni=0. A deselected edge neither writes the array nor drives the bus in the following cycle.
- R2: A read command (we_ni=1) at an accepted edge puts the word at that address on dq_io during the following cycle, provided oe_ni is low.
- R3: A write command (we_ni=0) at an accepted edge samples dq_io at the next accepted edge and stores it at the command's address. Lane i occupies bits [9i+8:9i], and bit 9i+8 is that lane's parity bit.
- R4: Lane i is written only if bw_ni[i] was low with the write command. Lanes whose strobe was high keep their earlier contents, including their parity bit.
- R5: A write command with all four strobes high leaves the addressed word unchanged.
- R6: While cen_ni is high, the edge is ignored. The captured command, address and bus state are held, and no pending write is committed. The pending write commits with the bus data at the next edge where cen_ni is low.
- R7: oe_ni high puts dq_io in high impedance without waiting for a clock edge. Returning it low restores the read data in the same cycle.
- R8: During the data phase of a write, dq_io is not driven by the block, even with oe_ni low.
- R9: While a select command is being presented after a deselected edge, dq_io stays in high impedance.
- R10: A read command presented at the very edge that commits a write to the same address returns the newly written data.
- R11: With rst_ni low, no command is pending and dq_io is in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the command pipeline |
| cen_ni | input | 1 | Active-low clock qualifier; high stretches the current cycle |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Active-low write enable |
| bw_ni | input | 4 | Active-low byte-lane write strobes |
| addr_i | input | 4 | Word address |
| oe_ni | input | 1 | Asynchronous active-low output enable |
| dq_io | inout | 36 | Data and parity bus, four 9-bit lanes |

## Verification
The hardest case to reach is a write data phase that overlaps a clock-enable stall. The stimulus presents a write command, then raises cen_ni while the bench drives a first data value. It then lowers cen_ni with a second value on the bus, and a later read must return only the second value. The back-to-back case needs careful bus handover. The bench drives write data up to the committing edge, which also captures a read of the same address. It releases the bus at the following falling edge and then expects the fresh word.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_ni,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bw_no
);
  logic sel;
  cmd_e cmd_d;

  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;

  always_comb begin
    cmd_d = CMD_IDLE;
    if (sel) cmd_d = we_ni ? CMD_READ : CMD_WRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= CMD_IDLE;
      addr_o <= '0;
      bw_no  <= '1;
    end else if (!cen_ni) begin
      cmd_o  <= cmd_d;
      addr_o <= addr_i;
      bw_no  <= bw_ni;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && lane_we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    // read follows the registered address, so a commit is visible next cycle
    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_io_ctrl.sv
module sram_io_ctrl
  import sram_pkg::*;
(
  input  cmd_e cmd_i,
  input  logic oe_ni,
  output logic drive_en_o
);
  // write data phase and deselect both leave cmd_i != CMD_READ
  assign drive_en_o = (cmd_i == CMD_READ) & ~oe_ni;
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_ni,
  inout  wire  [DATA_W-1:0] dq_io
);
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [LANES-1:0]  cmd_bw_nq;
  logic [DATA_W-1:0] rdata;
  logic              wr_en;
  logic              drive_en;

  sram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) cmd_stage_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cen_ni (cen_ni),
    .ce1_ni (ce1_ni),
    .ce2_i  (ce2_i),
    .ce3_ni (ce3_ni),
    .we_ni  (we_ni),
    .addr_i (addr_i),
    .bw_ni  (bw_ni),
    .cmd_o  (cmd_q),
    .addr_o (cmd_addr_q),
    .bw_no  (cmd_bw_nq)
  );

  assign wr_en = ~cen_ni & (cmd_q == CMD_WRITE);

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .lane_we_i (~cmd_bw_nq),
    .addr_i    (cmd_addr_q),
    .wdata_i   (dq_io),
    .rdata_o   (rdata)
  );

  sram_io_ctrl io_ctrl_i (
    .cmd_i      (cmd_q),
    .oe_ni      (oe_ni),
    .drive_en_o (drive_en)
  );

  assign dq_io = drive_en ? rdata : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input cmd_e              cmd_q,
  input logic [ADDR_W-1:0] cmd_addr_q,
  input logic              drive_en
);
  logic sel;
  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;

  // R7
  oe_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_en);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(cmd_q) && $stable(cmd_addr_q)));

  // R1
  desel_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !sel) |=> !drive_en);

  // R8
  wr_phase_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && sel && !we_ni) |=> !drive_en);

  // R2
  rd_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && sel && we_ni) |=> (cmd_q == CMD_READ && cmd_addr_q == $past(addr_i)));
endmodule

bind sram_pipe sram_pipe_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cen_ni     (cen_ni),
  .ce1_ni     (ce1_ni),
  .ce2_i      (ce2_i),
  .ce3_ni     (ce3_ni),
  .we_ni      (we_ni),
  .oe_ni      (oe_ni),
  .addr_i     (addr_i),
  .cmd_q      (cmd_q),
  .cmd_addr_q (cmd_addr_q),
  .drive_en   (drive_en)
);

// File: tb/sram_pipe_tb_top.sv
module sram_pipe_tb_top;
  localparam int AW = 4;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cen_ni = 1'b0, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic we_ni = 1'b1, oe_ni = 1'b0;
  logic [3:0] bw_ni = 4'hf;
  logic [AW-1:0] addr = '0;
  logic tb_en = 1'b0;
  logic [DW-1:0] tb_dq = '0;
  wire  [DW-1:0] dq;

  logic [DW-1:0] ref_mem [16];
  int n_chk = 0, n_bad = 0;

  assign dq = tb_en ? tb_dq : {DW{1'bz}};

  always #10 clk = ~clk;

  sram_pipe dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cen_ni(cen_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i),
    .ce3_ni(ce3_ni), .we_ni(we_ni), .bw_ni(bw_ni), .addr_i(addr), .oe_ni(oe_ni),
    .dq_io(dq)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(bit sel, bit wr, logic [3:0] bw, logic [AW-1:0] a);
    ce1_ni = ~sel; ce2_i = sel; ce3_ni = ~sel;
    we_ni = ~wr; bw_ni = bw; addr = a; cen_ni = 1'b0;
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] bw);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++) if (!bw[i]) r[9*i +: 9] = nw[9*i +: 9];
    return r;
  endfunction

  // write: command edge, then data edge; next command presented with the data
  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] bw, string req);
    cmd(1, 1, bw, a);
    step();
    #1 check({req, " R8 data phase hiz"}, dq, {DW{1'bz}});
    tb_dq = d; tb_en = 1'b1;
    cmd(0, 0, 4'hf, '0);
    step();
    tb_en = 1'b0;
    ref_mem[a] = merge(ref_mem[a], d, bw);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    cmd(1, 0, 4'hf, a);
    step();
    #1 check(req, dq, ref_mem[a]);
    cmd(0, 0, 4'hf, '0);
    step();
  endtask

  task automatic t_reset();
    #1 check("R11 reset hiz", dq, {DW{1'bz}});
    cmd(1, 0, 4'hf, 4'd0);
    step();
    #1 check("R11 held in reset hiz", dq, {DW{1'bz}});
    rst_ni = 1'b1;
    cmd(0, 0, 4'hf, '0);
    step();
  endtask

  task automatic t_fill();
    for (int a = 0; a < 16; a++) do_write(a[AW-1:0], {4{a[3:0], 5'h15}} ^ 36'h9_0000_0001, 4'h0, "R3");
    for (int a = 0; a < 16; a += 5) do_read(a[AW-1:0], "R2 R3 read back");
  endtask

  task automatic t_lanes();
    do_write(4'd3, 36'hA_BCDE_F012, 4'b1010, "R4");
    do_read(4'd3, "R4 partial lanes");
    do_write(4'd3, 36'h1_1111_1111, 4'b0111, "R4");
    do_read(4'd3, "R4 top lane parity");
    do_write(4'd4, 36'h5_5555_5555, 4'hf, "R5");
    do_read(4'd4, "R5 no strobes unchanged");
  endtask

  task automatic t_deselect();
    for (int k = 0; k < 3; k++) begin
      logic [DW-1:0] keep = ref_mem[6];
      cmd(0, 1, 4'h0, 4'd6);
      if (k == 0) begin ce2_i = 1'b1; ce3_ni = 1'b0; end
      if (k == 1) begin ce1_ni = 1'b0; ce3_ni = 1'b0; end
      if (k == 2) begin ce1_ni = 1'b0; ce2_i = 1'b1; end
      step();
      #1 check("R1 deselected no drive", dq, {DW{1'bz}});
      tb_dq = ~keep; tb_en = 1'b1;
      cmd(0, 0, 4'hf, '0);
      step();
      tb_en = 1'b0;
      // R9: select command presented right after deselect, bus still idle
      cmd(1, 0, 4'hf, 4'd6);
      #1 check("R9 first select cycle hiz", dq, {DW{1'bz}});
      step();
      #1 check("R1 deselected write ignored", dq, keep);
      cmd(0, 0, 4'hf, '0);
      step();
    end
  endtask

  task automatic t_oe();
    cmd(1, 0, 4'hf, 4'd7);
    step();
    #1 check("R2 read data", dq, ref_mem[7]);
    oe_ni = 1'b1;
    #1 check("R7 oe high hiz", dq, {DW{1'bz}});
    oe_ni = 1'b0;
    #1 check("R7 oe low restores", dq, ref_mem[7]);
    // R8: write command with oe low, data phase must not be driven
    cmd(0, 0, 4'hf, '0);
    step();
    do_write(4'd7, 36'h7_0F0F_0F0F, 4'h0, "R8");
    do_read(4'd7, "R8 write landed");
  endtask

  task automatic t_stall();
    // R6 stall during write data phase
    cmd(1, 1, 4'h0, 4'd9);
    step();
    tb_dq = 36'hD_EAD0_0001; tb_en = 1'b1;
    cmd(1, 0, 4'hf, 4'd2);
    cen_ni = 1'b1;
    step();
    tb_dq = 36'h2_BEEF_0002;
    cmd(0, 0, 4'hf, '0);
    step();
    tb_en = 1'b0;
    ref_mem[9] = 36'h2_BEEF_0002;
    do_read(4'd9, "R6 write commits after stall");
    // R6 stall during read output
    cmd(1, 0, 4'hf, 4'd10);
    step();
    #1 check("R2 read before stall", dq, ref_mem[10]);
    cmd(1, 0, 4'hf, 4'd11);
    cen_ni = 1'b1;
    step();
    #1 check("R6 output held during stall", dq, ref_mem[10]);
    cen_ni = 1'b0;
    step();
    #1 check("R6 resumes with new address", dq, ref_mem[11]);
    cmd(0, 0, 4'hf, '0);
    step();
  endtask

  task automatic t_back2back();
    cmd(1, 1, 4'h0, 4'd12);
    step();
    tb_dq = 36'hC_0FFE_E123; tb_en = 1'b1;
    cmd(1, 0, 4'hf, 4'd12);
    step();
    tb_en = 1'b0;
    ref_mem[12] = 36'hC_0FFE_E123;
    #1 check("R10 read after write same address", dq, ref_mem[12]);
    cmd(0, 0, 4'hf, '0);
    step();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_lanes();
    t_deselect();
    t_oe();
    t_stall();
    t_back2back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule